// File: doc/BRIEF.md
# SAR Conversion Sequencer

This block is the digital controller of a successive-approximation analog-to-digital converter. A conversion starts in one of two ways. With edge mode off, a one-cycle software start pulse begins it. With edge mode on, each rising edge of one selected trigger line begins it, and the software pulse is ignored. When a conversion starts, the block latches the requested channel and drives the channel multiplexer with it. It closes the sample-hold switch for a fixed sample window.

After the sample window, the block runs a binary search from the most significant bit down. It presents a trial code to the DAC and keeps a bit whenever the comparator reports that the held voltage is at or above the trial code. A fixed settle tail then brings the conversion to its full length. At the end, the busy flag drops, the interrupt request flag is raised, and the 10-bit code is published split across a 2-bit high register and an 8-bit low register.

The interrupt output is gated by an enable bit. Software clears the request flag with a clear pulse. A master enable at 0 aborts any conversion and keeps the block idle.

Top module: `sar_seq`

## Requirements
- R1: After reset, busy, irq_flag, irq and sh_close are 0, and res_hi and res_lo are 0.
- R2: With en=1 and ext_mode=0, a sw_start pulse sampled at a clock edge while idle sets busy from that edge on. mux_sel then shows the chan_sel value captured at that edge.
- R3: With ext_mode=1, a rising edge of trig_in[trig_sel] starts a conversion, and sw_start has no effect. Edges on unselected trigger lines never start a conversion. With ext_mode=0, trigger edges have no effect.
- R4: sh_close is 1 for exactly the first 16 busy cycles and only while busy. mux_sel holds the latched channel for the whole conversion.
- R5: During busy cycles 16 to 25, dac_code equals the bits already resolved OR'd with a single trial bit. The trial bit walks from bit 9 down to bit 0. A trial bit is kept when cmp_in is 1 at the end of its cycle. Outside these cycles, dac_code carries no trial bit.
- R6: A conversion that is not aborted keeps busy at 1 for exactly 38 cycles: a 16-cycle sample, a 10-cycle search and a 12-cycle settle.
- R7: At completion, busy falls, irq_flag becomes 1, res_hi takes code[9:8] and res_lo takes code[7:0]. The result registers change at no other time.
- R8: irq is 1 exactly when irq_flag and irq_en are both 1. An irq_clr pulse clears irq_flag, but a completion in the same cycle takes priority.
- R9: A software start or trigger edge that arrives while busy is ignored. The running conversion keeps its length and produces one result.
- R10: en=0 forces busy to 0 at the next edge without setting irq_flag, and no start is accepted while en=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Master enable |
| ext_mode | input | 1 | 1 selects trigger-edge starts, 0 selects software start |
| sw_start | input | 1 | Software start pulse |
| trig_in | input | 4 | Candidate trigger lines |
| trig_sel | input | 2 | Index of the active trigger line |
| chan_sel | input | 3 | Requested analog channel |
| irq_en | input | 1 | Interrupt enable |
| irq_clr | input | 1 | Clears the interrupt request flag |
| cmp_in | input | 1 | Comparator: 1 when held voltage >= dac_code |
| mux_sel | output | 3 | Channel multiplexer select |
| sh_close | output | 1 | Sample-hold switch closed |
| dac_code | output | 10 | Trial code for the DAC |
| busy | output | 1 | Conversion in progress |
| irq_flag | output | 1 | Interrupt request flag |
| irq | output | 1 | Gated interrupt output |
| res_hi | output | 2 | Result bits 9:8 |
| res_lo | output | 8 | Result bits 7:0 |

## Verification
Busy is due one cycle after the start request. The bench drives inputs and samples outputs on falling edges, so the first sample after the request already shows busy and the latched channel. Each later falling-edge sample is then the next busy cycle. This counting fixes three points: the sample switch must open after sample 15, the first trial code 512 must appear at sample 16, and busy must be low at sample 38. The monitor pops the expected code from the scoreboard queue on the first sample where busy is low. It checks irq_flag in that same sample. An abort or a rejected start is judged by observing busy a few cycles after the stimulus.

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int NBITS  = 10,
  parameter int NCH    = 8,
  parameter int NTRIG  = 4,
  parameter int SAMPLE = 16,
  parameter int TOTAL  = 38,
  localparam int CHW = $clog2(NCH),
  localparam int TW  = $clog2(NTRIG),
  localparam int CW  = $clog2(TOTAL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             ext_mode,
  input  logic             sw_start,
  input  logic [NTRIG-1:0] trig_in,
  input  logic [TW-1:0]    trig_sel,
  input  logic [CHW-1:0]   chan_sel,
  input  logic             irq_en,
  input  logic             irq_clr,
  input  logic             cmp_in,
  output logic [CHW-1:0]   mux_sel,
  output logic             sh_close,
  output logic [NBITS-1:0] dac_code,
  output logic             busy,
  output logic             irq_flag,
  output logic             irq,
  output logic [NBITS-9:0] res_hi,
  output logic [7:0]       res_lo
);
  localparam logic [CW-1:0]    S_END = CW'(SAMPLE);
  localparam logic [CW-1:0]    C_END = CW'(SAMPLE + NBITS);
  localparam logic [CW-1:0]    LAST  = CW'(TOTAL - 1);
  localparam logic [NBITS-1:0] MSB1  = {1'b1, {(NBITS-1){1'b0}}};

  logic [CW-1:0]    cnt;
  logic             busy_q, flag_q, trig_q;
  logic [CHW-1:0]   chan_q;
  logic [NBITS-1:0] sar_q, res_q;

  wire              trig_now = trig_in[trig_sel];
  wire              trig_rise = trig_now & ~trig_q;
  wire              start = en & ~busy_q & (ext_mode ? trig_rise : sw_start);
  wire              in_conv = busy_q && cnt >= S_END && cnt < C_END;
  wire [CW-1:0]     off = cnt - S_END;
  wire [NBITS-1:0]  trial = in_conv ? (MSB1 >> off) : '0;
  wire              done = busy_q && cnt == LAST;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt    <= '0;
      chan_q <= '0;
      sar_q  <= '0;
      res_q  <= '0;
    end else if (!en) begin
      busy_q <= 1'b0;
      cnt    <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt    <= '0;
      chan_q <= chan_sel;
      sar_q  <= '0;
    end else if (busy_q) begin
      cnt <= cnt + 1'b1;
      if (in_conv && cmp_in) sar_q <= sar_q | trial;
      if (done) begin
        busy_q <= 1'b0;
        res_q  <= sar_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      trig_q <= 1'b0;
    end else begin
      trig_q <= trig_now;
      if (en && done) flag_q <= 1'b1;
      else if (irq_clr) flag_q <= 1'b0;
    end
  end

  assign mux_sel  = chan_q;
  assign sh_close = busy_q && cnt < S_END;
  assign dac_code = sar_q | trial;
  assign busy     = busy_q;
  assign irq_flag = flag_q;
  assign irq      = flag_q & irq_en;
  assign res_hi   = res_q[NBITS-1:8];
  assign res_lo   = res_q[7:0];
endmodule

module sar_seq_chk #(
  parameter int NBITS  = 10,
  parameter int CHW    = 3,
  parameter int SAMPLE = 16,
  parameter int TOTAL  = 38
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             irq_clr,
  input logic [CHW-1:0]   mux_sel,
  input logic             sh_close,
  input logic             busy,
  input logic             irq_flag,
  input logic [NBITS-9:0] res_hi,
  input logic [7:0]       res_lo
);
  logic [15:0] bcnt, scnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt <= '0;
      scnt <= '0;
    end else begin
      bcnt <= busy ? bcnt + 16'd1 : 16'd0;
      scnt <= sh_close ? scnt + 16'd1 : 16'd0;
    end
  end

  // R4
  sh_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sh_close |-> busy);
  // R4
  chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(mux_sel));
  // R4
  sample_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sh_close) && busy |-> scnt == 16'(SAMPLE));
  // R6
  conv_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && $past(en) |-> bcnt == 16'(TOTAL));
  // R7
  done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && $past(en) |-> irq_flag);
  // R7
  res_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({res_hi, res_lo}) |-> $fell(busy));
  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(irq_clr) && !($fell(busy) && $past(en)) |-> !irq_flag);
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !busy);
endmodule

bind sar_seq sar_seq_chk #(.NBITS(NBITS), .CHW(CHW), .SAMPLE(SAMPLE), .TOTAL(TOTAL)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .irq_clr(irq_clr), .mux_sel(mux_sel),
  .sh_close(sh_close), .busy(busy), .irq_flag(irq_flag), .res_hi(res_hi), .res_lo(res_lo)
);

// File: tb/test_sar_seq.sv
module test_sar_seq;
  logic       clk = 0, rst_n = 0, en = 0, ext_mode = 0, sw_start = 0;
  logic [3:0] trig_in = '0;
  logic [1:0] trig_sel = '0;
  logic [2:0] chan_sel = '0;
  logic       irq_en = 0, irq_clr = 0, cmp_in;
  logic [2:0] mux_sel;
  logic       sh_close, busy, irq_flag, irq;
  logic [9:0] dac_code;
  logic [1:0] res_hi;
  logic [7:0] res_lo;

  logic [9:0] analog [8];
  logic [9:0] held = '0;
  int checks = 0, fails = 0;
  int exp_q[$];
  logic busy_d = 0;

  always #4 clk = ~clk;

  sar_seq i_sar_seq (.clk(clk), .rst_n(rst_n), .en(en), .ext_mode(ext_mode), .sw_start(sw_start),
    .trig_in(trig_in), .trig_sel(trig_sel), .chan_sel(chan_sel), .irq_en(irq_en), .irq_clr(irq_clr),
    .cmp_in(cmp_in), .mux_sel(mux_sel), .sh_close(sh_close), .dac_code(dac_code), .busy(busy),
    .irq_flag(irq_flag), .irq(irq), .res_hi(res_hi), .res_lo(res_lo));

  always @(posedge clk) if (sh_close) held <= analog[mux_sel];
  assign cmp_in = held >= dac_code;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // scoreboard monitor: completion of a conversion that ran with en high
  always @(negedge clk) begin
    if (rst_n && busy_d && !busy && en) begin
      if (exp_q.size() == 0) chk("R9 unexpected result", 1, 0);
      else begin
        int e;
        e = exp_q.pop_front();
        chk("R7 result", {22'd0, res_hi, res_lo}, e);
        chk("R7 irq_flag at completion", irq_flag, 1);
      end
    end
    busy_d = busy;
  end

  task automatic start_sw(input int ch);
    @(negedge clk);
    chan_sel = ch[2:0];
    sw_start = 1;
    @(negedge clk);
    sw_start = 0;
  endtask

  task automatic run_conv(input int ch, input int val, input bit poke);
    int n_busy = 0, n_sh = 0;
    analog[ch] = val[9:0];
    exp_q.push_back(val);
    start_sw(ch);
    chk("R2 busy after start", busy, 1);
    chk("R2 channel latched", mux_sel, ch);
    while (busy && n_busy < 100) begin
      if (sh_close) n_sh++;
      if (n_busy == 15) chk("R5 no trial in sample", dac_code, 0);
      if (n_busy == 16) chk("R5 first trial MSB", dac_code, 512);
      if (n_busy == 17) chk("R5 second trial", dac_code, (val & 512) | 256);
      if (n_busy == 20) analog[ch] = ~val[9:0];
      sw_start = poke && n_busy == 5;
      n_busy++;
      @(negedge clk);
    end
    sw_start = 0;
    chk("R6 busy length", n_busy, 38);
    chk("R4 sample length", n_sh, 16);
    chk("R4 mux held", mux_sel, ch);
  endtask

  initial begin
    int wd = 0;
    while (wd < 100000) begin @(posedge clk); wd++; end
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) analog[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk("R1 busy", busy, 0);
    chk("R1 irq_flag", irq_flag, 0);
    chk("R1 sh_close", sh_close, 0);
    chk("R1 result", {res_hi, res_lo}, 0);
    chk("R1 irq", irq, 0);
    en = 1;

    run_conv(3, 'h2A5, 0);
    @(negedge clk);
    chk("R8 irq gated off", irq, 0);
    irq_en = 1;
    @(negedge clk);
    chk("R8 irq on", irq, 1);
    irq_clr = 1;
    @(negedge clk);
    irq_clr = 0;
    chk("R8 flag cleared", irq_flag, 0);
    chk("R8 irq cleared", irq, 0);

    run_conv(0, 0, 0);
    run_conv(7, 1023, 0);
    run_conv(5, 512, 0);
    run_conv(1, 511, 0);

    // R9: start while busy
    run_conv(6, 'h155, 1);
    repeat (4) @(negedge clk);
    chk("R9 no restart", busy, 0);
    irq_clr = 1;
    @(negedge clk);
    irq_clr = 0;

    // R3: edge mode
    ext_mode = 1;
    trig_sel = 2;
    @(negedge clk);
    sw_start = 1;
    @(negedge clk);
    sw_start = 0;
    repeat (2) @(negedge clk);
    chk("R3 sw ignored in edge mode", busy, 0);
    trig_in[1] = 1;
    repeat (3) @(negedge clk);
    chk("R3 unselected line ignored", busy, 0);
    analog[4] = 'h0C3;
    exp_q.push_back('h0C3);
    chan_sel = 4;
    trig_in[2] = 1;
    @(negedge clk);
    chk("R3 edge starts", busy, 1);
    chk("R3 channel", mux_sel, 4);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R3 level does not retrigger", busy, 0);
    trig_in[2] = 0;
    repeat (2) @(negedge clk);
    analog[2] = 'h3F0;
    exp_q.push_back('h3F0);
    chan_sel = 2;
    trig_in[2] = 1;
    @(negedge clk);
    chk("R3 second edge starts", busy, 1);
    while (busy) @(negedge clk);
    trig_in[2] = 0;
    ext_mode = 0;
    repeat (2) @(negedge clk);
    trig_in[2] = 1;
    repeat (3) @(negedge clk);
    chk("R3 edge ignored in sw mode", busy, 0);
    trig_in = '0;
    irq_clr = 1;
    @(negedge clk);
    irq_clr = 0;

    // R10: abort and idle
    start_sw(2);
    repeat (20) @(negedge clk);
    en = 0;
    @(negedge clk);
    chk("R10 abort", busy, 0);
    start_sw(1);
    @(negedge clk);
    chk("R10 no start while disabled", busy, 0);
    chk("R10 no flag on abort", irq_flag, 0);
    chk("R10 result untouched", {res_hi, res_lo}, 'h3F0);
    en = 1;
    run_conv(2, 'h201, 0);
    repeat (2) @(negedge clk);
    chk("R7 queue drained", exp_q.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule